// File: doc/BRIEF.md
# Staged Byte RAM

This block is a small random-access store of byte-wide cells. It is reached only through two holding registers. One register keeps the address of the cell to access. The other keeps the byte to be written, or the byte that was read back. A client first fills the holding registers through their load strobes. It then raises a start strobe, with a command line that picks between reading a cell (fetch) and writing a cell (store). After a fixed latency, a single-cycle done pulse marks the end of the access. After a fetch, the byte read is on the data output.

The address is split into two halves, and each half has its own small decoder. The upper half drives a row decoder and the lower half drives a column decoder. A cell is selected where an active row line meets an active column line. The access takes the same number of cycles for every cell. The cells themselves are flip-flops inside the block. Reset clears the staging registers but leaves the cell contents alone.

Top module: `staged_ram`

## Requirements
- R1: There are 256 cells of 8 bits each, at addresses 0 to 255. Address bits [7:4] select the row and bits [3:0] select the column. A store to one cell leaves every other cell unchanged, and a fetch returns the last byte stored to that same address.
- R2: While reset_n is low, data_out is 0 and done is 0. The address register is also cleared. Cell contents written before a reset are still there after it.
- R3: When no access is in progress, a high load_data at a clock edge copies data_in into the data register, and data_out shows it from that edge on. In the same situation, a high load_addr copies addr_in into the address register.
- R4: A start sampled high at edge k, with no access in progress and cmd_write = 0 (fetch), makes done high for exactly the one cycle after edge k+2. In that same cycle data_out shows the addressed cell, and the cell itself is left unchanged.
- R5: A start accepted with cmd_write = 1 (store) writes the data register into the addressed cell at edge k+2. The old byte is lost, data_out keeps its value, and done is pulsed as in R4.
- R6: A start that arrives at edge k+1 or k+2 of an access in progress is ignored and does not produce an extra done pulse.
- R7: load_addr and load_data are ignored at edges k+1 and k+2 of an access in progress. They change neither the cell used nor data_out.
- R8: cmd_write is sampled only at the edge where start is accepted. Changing it later in the access has no effect.
- R9: done is low outside the pulses of R4. The start-to-done latency is the same for every address, including the lowest, the highest and the row and column ends.
- R10: A load_addr or load_data at the same edge as an accepted start takes effect, and that access uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| reset_n | input | 1 | Synchronous reset, active low |
| load_addr | input | 1 | Copy addr_in into the address register |
| addr_in | input | 8 | Address to stage |
| load_data | input | 1 | Copy data_in into the data register |
| data_in | input | 8 | Byte to stage |
| start | input | 1 | Begin an access |
| cmd_write | input | 1 | 1 = store, 0 = fetch; sampled with start |
| data_out | output | 8 | Contents of the data register |
| done | output | 1 | One-cycle pulse at the end of an access |

## Verification
The properties assume that every input is a clean 0 or 1 at each rising edge once reset is released, and that a strobe counts at every edge where it is sampled high, not only on its rising edge. The bench meets this by changing inputs only on falling edges and by dropping each strobe after one cycle, except where a held strobe is the point of the test. It also holds start through a running access on purpose, and it drives load strobes and cmd_write changes inside the busy window. Reset is applied only while the block is idle, so the checker's own phase counter and the design always start from the same state.

// File: rtl/staged_ram_pkg.sv
package staged_ram_pkg;

    // Access sequencer phases
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_DECODE = 2'd1,
        PH_XFER   = 2'd2
    } phase_e;

    // Command captured with an accepted start
    typedef enum logic {
        OP_FETCH = 1'b0,
        OP_STORE = 1'b1
    } op_e;

endpackage

// File: rtl/onehot_dec.sv
// Binary to one-hot decoder for one half of the address.
module onehot_dec #(
    parameter int SEL_W = 4
) (
    input  logic [SEL_W-1:0]      sel,
    output logic [(1<<SEL_W)-1:0] lines
);
    localparam int LINES = 1 << SEL_W;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign lines[i] = (sel == SEL_W'(i));
    end
endmodule

// File: rtl/cell_array.sv
// Grid of byte cells made of flip-flops. A cell is chosen where the
// active row line crosses the active column line.
module cell_array #(
    parameter int DATA_W = 8,
    parameter int ROWS   = 16,
    parameter int COLS   = 16
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ROWS-1:0]   row_sel,
    input  logic [COLS-1:0]   col_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int CELLS = ROWS * COLS;

    logic [CELLS*DATA_W-1:0] terms;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            logic [DATA_W-1:0] cell_q;
            logic              hit;

            assign hit = row_sel[r] & col_sel[c];

            always_ff @(posedge clk) begin
                if (wr_en && hit) begin
                    cell_q <= wdata;
                end
            end

            assign terms[(r*COLS+c)*DATA_W +: DATA_W] = hit ? cell_q : '0;
        end
    end

    // AND-OR read path: only the selected cell contributes
    always_comb begin
        rdata = '0;
        for (int i = 0; i < CELLS; i++) begin
            rdata = rdata | terms[i*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/staged_ram.sv
module staged_ram
    import staged_ram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              reset_n,
    input  logic              load_addr,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              load_data,
    input  logic [DATA_W-1:0] data_in,
    input  logic              start,
    input  logic              cmd_write,
    output logic [DATA_W-1:0] data_out,
    output logic              done
);
    localparam int ROW_W = ADDR_W / 2;
    localparam int COL_W = ADDR_W - ROW_W;
    localparam int ROWS  = 1 << ROW_W;
    localparam int COLS  = 1 << COL_W;

    typedef struct packed {
        phase_e            phase;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [ROWS-1:0]   row_sel;
        logic [COLS-1:0]   col_sel;
        logic              done;
    } state_t;

    state_t s_d, s_q;

    logic [ROWS-1:0]   row_lines;
    logic [COLS-1:0]   col_lines;
    logic [DATA_W-1:0] rd_data;
    logic              arr_we;

    // Two half-width decoders in place of one full-width decoder
    onehot_dec #(.SEL_W(ROW_W)) i_row_dec (
        .sel   (s_q.addr[ADDR_W-1 -: ROW_W]),
        .lines (row_lines)
    );

    onehot_dec #(.SEL_W(COL_W)) i_col_dec (
        .sel   (s_q.addr[COL_W-1:0]),
        .lines (col_lines)
    );

    assign arr_we = (s_q.phase == PH_XFER) && (s_q.op == OP_STORE);

    cell_array #(
        .DATA_W (DATA_W),
        .ROWS   (ROWS),
        .COLS   (COLS)
    ) i_cells (
        .clk     (clk),
        .wr_en   (arr_we),
        .row_sel (s_q.row_sel),
        .col_sel (s_q.col_sel),
        .wdata   (s_q.data),
        .rdata   (rd_data)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (load_addr) begin
                    s_d.addr = addr_in;
                end
                if (load_data) begin
                    s_d.data = data_in;
                end
                if (start) begin
                    s_d.phase = PH_DECODE;
                    s_d.op    = op_e'(cmd_write);
                end
            end
            PH_DECODE: begin
                // latch the decoded lines so the transfer sees a stable select
                s_d.row_sel = row_lines;
                s_d.col_sel = col_lines;
                s_d.phase   = PH_XFER;
            end
            PH_XFER: begin
                if (s_q.op == OP_FETCH) begin
                    s_d.data = rd_data;
                end
                s_d.done    = 1'b1;
                s_d.row_sel = '0;
                s_d.col_sel = '0;
                s_d.phase   = PH_IDLE;
            end
            default: begin
                s_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!reset_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign data_out = s_q.data;
    assign done     = s_q.done;
endmodule

// File: rtl/staged_ram_chk.sv
// Port-level checker with its own phase counter.
module staged_ram_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              reset_n,
    input logic              load_data,
    input logic              start,
    input logic              cmd_write,
    input logic [DATA_W-1:0] data_out,
    input logic              done
);
    logic [1:0] ph_q;
    logic       exp_done_q;
    logic       op_q;

    always_ff @(posedge clk) begin
        if (!reset_n) begin
            ph_q       <= 2'd0;
            exp_done_q <= 1'b0;
            op_q       <= 1'b0;
        end else begin
            exp_done_q <= (ph_q == 2'd2);
            case (ph_q)
                2'd0: begin
                    if (start) begin
                        ph_q <= 2'd1;
                        op_q <= cmd_write;
                    end
                end
                2'd1:    ph_q <= 2'd2;
                default: ph_q <= 2'd0;
            endcase
        end
    end

    // R4, R6: done follows an accepted start by exactly two edges
    a_r4_done_latency: assert property (@(posedge clk) disable iff (!reset_n)
        done == exp_done_q);

    // R9: done is a single-cycle pulse
    a_r9_done_single: assert property (@(posedge clk) disable iff (!reset_n)
        done |=> !done);

    // R5: a completed store leaves data_out unchanged
    a_r5_store_keeps_data: assert property (@(posedge clk) disable iff (!reset_n)
        (done && op_q) |-> $stable(data_out));

    // R7: data_out moves only on a data load or a fetch completion
    a_r7_data_hold: assert property (@(posedge clk) disable iff (!reset_n)
        (!$past(load_data) && !done) |-> $stable(data_out));
endmodule

bind staged_ram staged_ram_chk #(.DATA_W(DATA_W)) i_staged_ram_chk (
    .clk       (clk),
    .reset_n   (reset_n),
    .load_data (load_data),
    .start     (start),
    .cmd_write (cmd_write),
    .data_out  (data_out),
    .done      (done)
);

// File: tb/test_staged_ram.sv
`timescale 1ns/1ps
module test_staged_ram;
    logic       clk = 1'b0;
    logic       reset_n = 1'b0;
    logic       load_addr = 1'b0;
    logic [7:0] addr_in = 8'd0;
    logic       load_data = 1'b0;
    logic [7:0] data_in = 8'd0;
    logic       start = 1'b0;
    logic       cmd_write = 1'b0;
    logic [7:0] data_out;
    logic       done;

    always #2.5 clk = ~clk;

    staged_ram i_staged_ram (
        .clk       (clk),
        .reset_n   (reset_n),
        .load_addr (load_addr),
        .addr_in   (addr_in),
        .load_data (load_data),
        .data_in   (data_in),
        .start     (start),
        .cmd_write (cmd_write),
        .data_out  (data_out),
        .done      (done)
    );

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    bit    run = 1'b0;
    bit    finished = 1'b0;
    string cur_req = "R2";
    logic [7:0] golden [256];

    // Behavioural reference model
    logic [7:0] m_mem [256];
    int         m_phase = 0;
    logic       m_op = 1'b0;
    logic [7:0] m_addr = 8'd0;
    logic [7:0] m_data = 8'd0;
    logic       m_done = 1'b0;

    always @(posedge clk) begin
        if (!reset_n) begin
            m_phase = 0; m_op = 1'b0; m_addr = 8'd0; m_data = 8'd0; m_done = 1'b0;
        end else begin
            m_done = 1'b0;
            if (m_phase == 0) begin
                if (load_addr) m_addr = addr_in;
                if (load_data) m_data = data_in;
                if (start) begin
                    m_phase = 1;
                    m_op = cmd_write;
                end
            end else if (m_phase == 1) begin
                m_phase = 2;
            end else begin
                if (m_op) m_mem[m_addr] = m_data;
                else      m_data = m_mem[m_addr];
                m_done  = 1'b1;
                m_phase = 0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Compare against the model on every clock
    always @(negedge clk) begin
        if (run && !finished) begin
            chk(cur_req, {24'd0, data_out}, {24'd0, m_data}, "data_out vs model");
            chk(cur_req, {31'd0, done}, {31'd0, m_done}, "done vs model");
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000 && !finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic store(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); load_addr = 1'b1; addr_in = a; load_data = 1'b1; data_in = d;
        @(negedge clk); load_addr = 1'b0; load_data = 1'b0; start = 1'b1; cmd_write = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic fetch(input logic [7:0] a);
        @(negedge clk); load_addr = 1'b1; addr_in = a;
        @(negedge clk); load_addr = 1'b0; start = 1'b1; cmd_write = 1'b0;
        @(negedge clk); start = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int cnt;
        logic [7:0] lat_addr [4];
        lat_addr[0] = 8'h00; lat_addr[1] = 8'hFF; lat_addr[2] = 8'h0F; lat_addr[3] = 8'hF0;
        run = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2", {24'd0, data_out}, 32'd0, "data_out in reset");
        chk("R2", {31'd0, done}, 32'd0, "done in reset");
        reset_n = 1'b1;

        // R3: staged data appears on data_out
        cur_req = "R3";
        @(negedge clk); load_data = 1'b1; data_in = 8'hA5;
        @(negedge clk); load_data = 1'b0;
        chk("R3", {24'd0, data_out}, 32'hA5, "data register load");

        // R5: store every cell
        cur_req = "R5";
        for (int a = 0; a < 256; a++) begin
            golden[a] = 8'((a * 37 + 11) & 255);
            store(8'(a), golden[a]);
            chk("R5", {24'd0, data_out}, {24'd0, golden[a]}, "data_out after store");
        end

        // R1: every cell returns its own byte
        cur_req = "R1";
        for (int a = 0; a < 256; a++) begin
            fetch(8'(a));
            chk("R1", {24'd0, data_out}, {24'd0, golden[a]}, "fetched byte");
        end

        // R4: fetch does not disturb the cell
        cur_req = "R4";
        fetch(8'h3C);
        fetch(8'h3C);
        chk("R4", {24'd0, data_out}, {24'd0, golden[8'h3C]}, "second fetch");

        // R9: equal latency for corner addresses
        cur_req = "R9";
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); load_addr = 1'b1; addr_in = lat_addr[i];
            @(negedge clk); load_addr = 1'b0; start = 1'b1; cmd_write = 1'b0;
            cnt = 0;
            do begin
                @(negedge clk); start = 1'b0; cnt++;
            end while (!done && cnt < 10);
            chk("R9", cnt, 3, "start-to-done latency");
            chk("R9", {24'd0, data_out}, {24'd0, golden[lat_addr[i]]}, "corner fetch");
        end

        // R6: start held through the access
        cur_req = "R6";
        @(negedge clk); load_addr = 1'b1; addr_in = 8'h21;
        @(negedge clk); load_addr = 1'b0; start = 1'b1; cmd_write = 1'b0;
        cnt = 0;
        @(negedge clk); cnt += int'(done);
        @(negedge clk); cnt += int'(done);
        @(negedge clk); cnt += int'(done); start = 1'b0;
        repeat (5) begin @(negedge clk); cnt += int'(done); end
        chk("R6", cnt, 1, "done pulses for held start");

        // R7: loads during an access are ignored
        cur_req = "R7";
        @(negedge clk); load_addr = 1'b1; addr_in = 8'h40;
        @(negedge clk); load_addr = 1'b0; start = 1'b1; cmd_write = 1'b0;
        @(negedge clk); start = 1'b0; load_addr = 1'b1; addr_in = 8'h41;
        load_data = 1'b1; data_in = 8'hEE;
        @(negedge clk);
        @(negedge clk); load_addr = 1'b0; load_data = 1'b0;
        chk("R7", {24'd0, data_out}, {24'd0, golden[8'h40]}, "fetch with busy loads");
        @(negedge clk); start = 1'b1; cmd_write = 1'b0;
        @(negedge clk); start = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7", {24'd0, data_out}, {24'd0, golden[8'h40]}, "address kept after busy load");

        // R8: command changes after start have no effect
        cur_req = "R8";
        @(negedge clk); load_addr = 1'b1; addr_in = 8'h50; load_data = 1'b1; data_in = 8'h99;
        @(negedge clk); load_addr = 1'b0; load_data = 1'b0; start = 1'b1; cmd_write = 1'b1;
        @(negedge clk); start = 1'b0; cmd_write = 1'b0;
        repeat (2) @(negedge clk);
        golden[8'h50] = 8'h99;
        @(negedge clk); load_addr = 1'b1; addr_in = 8'h51;
        @(negedge clk); load_addr = 1'b0; start = 1'b1; cmd_write = 1'b0;
        @(negedge clk); start = 1'b0; cmd_write = 1'b1;
        repeat (2) @(negedge clk);
        cmd_write = 1'b0;
        chk("R8", {24'd0, data_out}, {24'd0, golden[8'h51]}, "fetch kept as fetch");
        fetch(8'h50);
        chk("R8", {24'd0, data_out}, 32'h99, "store kept as store");
        fetch(8'h51);
        chk("R8", {24'd0, data_out}, {24'd0, golden[8'h51]}, "cell not overwritten");

        // R10: loads on the start edge are used
        cur_req = "R10";
        @(negedge clk); load_addr = 1'b1; addr_in = 8'h77; load_data = 1'b1; data_in = 8'h3C;
        start = 1'b1; cmd_write = 1'b1;
        @(negedge clk); load_addr = 1'b0; load_data = 1'b0; start = 1'b0;
        repeat (2) @(negedge clk);
        golden[8'h77] = 8'h3C;
        fetch(8'h77);
        chk("R10", {24'd0, data_out}, 32'h3C, "same-edge store");

        // R2: contents survive reset
        cur_req = "R2";
        @(negedge clk); reset_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2", {24'd0, data_out}, 32'd0, "data cleared by reset");
        reset_n = 1'b1;
        fetch(8'h77);
        chk("R2", {24'd0, data_out}, 32'h3C, "cell kept through reset");
        fetch(8'h00);
        chk("R2", {24'd0, data_out}, {24'd0, golden[0]}, "cell 0 kept through reset");

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule